// File: doc/BRIEF.md
# Radix page table walker

This block turns a 64-bit effective address into a real address by walking a radix tree that lives in ordinary memory. A walk begins from a process-table base register and a process ID. The engine first reads the process-table entry for that process. The entry gives the tree size, the size of the root index, and the root base. The engine then checks that the effective address lies inside the tree. It reads one 8-byte directory entry per level until it meets a leaf, an invalid entry or a malformed level. Each level's index width is compared against a remaining-shift budget that shrinks as the walk descends. Entry addresses and the final real address are formed by merging base bits with address bits under generated low-order masks, not by addition.

A caller presents a request while the engine is idle and gets back a one-cycle completion with either a real address or exactly one error flag. The raw leaf entry is also returned so that a separate permission checker can evaluate it. The engine has one memory read outstanding at a time and accepts a response after any latency of one cycle or more.

Top module: `rpw_walker`

## Requirements
- R1: `req_ready` is high exactly while the engine is idle. A request is accepted only when `req_valid` and `req_ready` are both high. Requests raised during a walk are ignored and do not change the walk in progress. Acceptance clears the error flags, `real_addr` and `leaf_entry`.
- R2: The first read of a walk goes to {8'h00, base[55:36], (base[35:12] & ~M) | (pid[31:8] & M), pid[7:0], 4'h0}. Here `base` is `proc_tbl_base` and M is a 24-bit mask whose low `proc_tbl_base[4:0]` bits are ones.
- R3: When effective address bit 63 is 1, the process ID used for R2 is zero, whatever `req_pid` holds.
- R4: From the process-table entry, the tree shift is {0, bits 62:61, bits 7:5}, the root index width is {0, bits 4:0}, and the root base is {bits 55:8, 8'h00}.
- R5: After the process-table read, `err_segment` ends the walk in either of two cases: address bit 63 differs from bit 62, or any of address bits 61:31 is set outside the low "tree shift" bits.
- R6: `err_bad_tree` ends the walk in any of these cases. At the root, the index width is below 5, above 16, or above shift+19; in that case the remaining shift would otherwise become shift+19-width. At a lower level, the width in bits 4:0 of a non-leaf entry is below 5, above 16, or above the remaining shift.
- R7: A directory entry with bit 63 clear ends the walk with `err_invalid`. When bit 63 is set, bit 62 selects a leaf (1) or a next level (0). A next-level entry supplies base {bits 55:8, 8'h00} and reduces the remaining shift by its width.
- R8: A directory read goes to {8'h00, base[55:19], (base[18:3] & ~K) | (S & K), 3'b000}. K has as many low ones as the current index width. S is the low 16 bits of address bits 61:12 shifted right by the remaining shift.
- R9: On a leaf, `real_addr` = {8'h00, (leaf[55:12] & ~F) | (ea[55:12] & F), leaf[11:0]}, where F has as many low ones as the remaining shift. `leaf_entry` returns the leaf unchanged.
- R10: `done` is a one-cycle pulse per walk. At most one error flag is set. `real_addr` and `leaf_entry` read zero when an error flag is set.
- R11: `mem_req_valid` is a one-cycle pulse. No new read is issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request |
| req_ea | input | 64 | Effective address to translate |
| req_pid | input | PID_W | Process ID |
| proc_tbl_base | input | 64 | Process-table base and size register |
| req_ready | output | 1 | Engine idle, request can be taken |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | 64 | Read address of an 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Walk complete, one cycle |
| real_addr | output | 64 | Translated real address |
| leaf_entry | output | 64 | Leaf entry for the permission check |
| err_bad_tree | output | 1 | Malformed level size |
| err_invalid | output | 1 | Invalid directory entry |
| err_segment | output | 1 | Address outside the tree |

## Verification
A wrong shift budget or index mask inside the engine shows up at the memory port first: the next read address moves to another entry. The reply that comes back then turns into a wrong real address, a spurious invalid or bad-tree flag, or a wrong number of reads, all visible at the `done` pulse of the same walk. The bench sweeps a small two-level tree over many index values and response latencies, with huge and normal leaves, and compares each completion with values computed from the formulas above. A corrupted walk state therefore appears within one walk.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PT_READ,
      ST_SEG_CHECK,
      ST_LOOKUP,
      ST_FINISH
   } walk_state_t;

   typedef struct packed {
      logic bad_tree;
      logic invalid;
      logic segment;
   } walk_err_t;

   localparam int unsigned SHIFT_W    = 6;
   localparam int unsigned PT_MASK_W  = 24;
   localparam int unsigned IDX_MASK_W = 16;
   localparam int unsigned FIN_MASK_W = 44;
   localparam int unsigned SEG_MASK_W = 31;

endpackage

// File: rtl/rpw_lowmask.sv
module rpw_lowmask #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned CNT_W = 6
) (
   input  logic [CNT_W-1:0] count,
   output logic [WIDTH-1:0] mask
);
   if (WIDTH < 1 || CNT_W < 1 || CNT_W > 31) begin : g_bad_cfg
      $error("rpw_lowmask: WIDTH and CNT_W out of range");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign mask[i] = (32'(count) > 32'(i));
   end
endmodule

// File: rtl/rpw_addr_gen.sv
module rpw_addr_gen
   import rpw_pkg::*;
#(
   parameter int unsigned PID_W = 32
) (
   input  logic [63:0]         ptbr,
   input  logic [63:0]         ea,
   input  logic [PID_W-1:0]    pid,
   input  logic [SHIFT_W-1:0]  shift,
   input  logic [SHIFT_W-1:0]  idx_bits,
   input  logic [55:0]         base,
   input  logic [63:0]         leaf,
   output logic [63:0]         pt_addr,
   output logic [63:0]         dir_addr,
   output logic [63:0]         real_addr,
   output logic                seg_fault
);
   if (PID_W < 8 || PID_W > 32) begin : g_bad_pid
      $error("rpw_addr_gen: PID_W must lie in 8..32");
   end

   logic [PT_MASK_W-1:0]  m_pt;
   logic [IDX_MASK_W-1:0] m_idx;
   logic [FIN_MASK_W-1:0] m_fin;
   logic [SEG_MASK_W-1:0] m_seg;
   logic [31:0]           eff_pid;
   logic [49:0]           ea_sh;

   rpw_lowmask #(.WIDTH(PT_MASK_W),  .CNT_W(SHIFT_W)) u_m_pt  (.count({1'b0, ptbr[4:0]}), .mask(m_pt));
   rpw_lowmask #(.WIDTH(IDX_MASK_W), .CNT_W(SHIFT_W)) u_m_idx (.count(idx_bits),          .mask(m_idx));
   rpw_lowmask #(.WIDTH(FIN_MASK_W), .CNT_W(SHIFT_W)) u_m_fin (.count(shift),             .mask(m_fin));
   rpw_lowmask #(.WIDTH(SEG_MASK_W), .CNT_W(SHIFT_W)) u_m_seg (.count(shift),             .mask(m_seg));

   always_comb begin
      eff_pid   = ea[63] ? 32'd0 : 32'(pid);
      pt_addr   = {8'h00, ptbr[55:36],
                   (ptbr[35:12] & ~m_pt) | (eff_pid[31:8] & m_pt),
                   eff_pid[7:0], 4'h0};
      ea_sh     = ea[61:12] >> shift;
      dir_addr  = {8'h00, base[55:19],
                   (base[18:3] & ~m_idx) | (ea_sh[15:0] & m_idx),
                   3'b000};
      real_addr = {8'h00,
                   (leaf[55:12] & ~m_fin) | (ea[55:12] & m_fin),
                   leaf[11:0]};
      seg_fault = (ea[63] ^ ea[62]) | (|(ea[61:31] & ~m_seg));
   end

   logic unused_bits;
   assign unused_bits = ^{ptbr[63:56], ptbr[11:5], ea[11:0], ea_sh[49:16],
                          base[2:0], leaf[63:56]};
endmodule

// File: rtl/rpw_walker.sv
module rpw_walker
   import rpw_pkg::*;
#(
   parameter int unsigned PID_W     = 32,
   parameter int unsigned MIN_IDX   = 5,
   parameter int unsigned MAX_IDX   = 16,
   parameter int unsigned ROOT_BIAS = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [63:0]       req_ea,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [63:0]       proc_tbl_base,
   output logic              req_ready,
   output logic              mem_req_valid,
   output logic [63:0]       mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_data,
   output logic              done,
   output logic [63:0]       real_addr,
   output logic [63:0]       leaf_entry,
   output logic              err_bad_tree,
   output logic              err_invalid,
   output logic              err_segment
);
   localparam int unsigned LIM_W = SHIFT_W + 1;

   if (MIN_IDX < 1 || MAX_IDX > IDX_MASK_W || MIN_IDX > MAX_IDX) begin : g_bad_idx
      $error("rpw_walker: index width bounds out of range");
   end
   if (ROOT_BIAS + 31 >= (1 << SHIFT_W)) begin : g_bad_bias
      $error("rpw_walker: ROOT_BIAS overflows the shift budget");
   end

   walk_state_t        state_q;
   walk_err_t          err_q;
   logic [63:0]        ea_q, ptbr_q, real_q, leaf_q, maddr_q;
   logic [PID_W-1:0]   pid_q;
   logic [SHIFT_W-1:0] shift_q, idx_q;
   logic [55:0]        base_q;
   logic               issue_q, mreq_q;

   logic [63:0]        pt_addr, dir_addr, leaf_real;
   logic               seg_fault;

   rpw_addr_gen #(.PID_W(PID_W)) u_addr (
      .ptbr      (ptbr_q),
      .ea        (ea_q),
      .pid       (pid_q),
      .shift     (shift_q),
      .idx_bits  (idx_q),
      .base      (base_q),
      .leaf      (mem_rsp_data),
      .pt_addr   (pt_addr),
      .dir_addr  (dir_addr),
      .real_addr (leaf_real),
      .seg_fault (seg_fault)
   );

   logic [SHIFT_W-1:0] rsp_idx, rsp_shift;
   logic [55:0]        rsp_base;
   logic [LIM_W-1:0]   root_limit, root_diff;
   logic               root_bad, lvl_bad;

   always_comb begin
      rsp_idx    = {1'b0, mem_rsp_data[4:0]};
      rsp_shift  = {1'b0, mem_rsp_data[62:61], mem_rsp_data[7:5]};
      rsp_base   = {mem_rsp_data[55:8], 8'h00};
      root_limit = {1'b0, shift_q} + LIM_W'(ROOT_BIAS);
      root_diff  = root_limit - {1'b0, idx_q};
      root_bad   = (idx_q < SHIFT_W'(MIN_IDX)) || (idx_q > SHIFT_W'(MAX_IDX)) ||
                   ({1'b0, idx_q} > root_limit);
      lvl_bad    = (rsp_idx < SHIFT_W'(MIN_IDX)) || (rsp_idx > SHIFT_W'(MAX_IDX)) ||
                   (rsp_idx > shift_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= '0;
         ea_q    <= '0;
         ptbr_q  <= '0;
         pid_q   <= '0;
         real_q  <= '0;
         leaf_q  <= '0;
         maddr_q <= '0;
         shift_q <= '0;
         idx_q   <= '0;
         base_q  <= '0;
         issue_q <= 1'b0;
         mreq_q  <= 1'b0;
      end else begin
         mreq_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  ea_q    <= req_ea;
                  pid_q   <= req_pid;
                  ptbr_q  <= proc_tbl_base;
                  err_q   <= '0;
                  real_q  <= '0;
                  leaf_q  <= '0;
                  issue_q <= 1'b1;
                  state_q <= ST_PT_READ;
               end
            end
            ST_PT_READ: begin
               if (issue_q) begin
                  mreq_q  <= 1'b1;
                  maddr_q <= pt_addr;
                  issue_q <= 1'b0;
               end else if (mem_rsp_valid) begin
                  shift_q <= rsp_shift;
                  idx_q   <= rsp_idx;
                  base_q  <= rsp_base;
                  state_q <= ST_SEG_CHECK;
               end
            end
            ST_SEG_CHECK: begin
               if (seg_fault) begin
                  err_q.segment <= 1'b1;
                  state_q       <= ST_FINISH;
               end else if (root_bad) begin
                  err_q.bad_tree <= 1'b1;
                  state_q        <= ST_FINISH;
               end else begin
                  shift_q <= root_diff[SHIFT_W-1:0];
                  issue_q <= 1'b1;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (issue_q) begin
                  mreq_q  <= 1'b1;
                  maddr_q <= dir_addr;
                  issue_q <= 1'b0;
               end else if (mem_rsp_valid) begin
                  if (!mem_rsp_data[63]) begin
                     err_q.invalid <= 1'b1;
                     state_q       <= ST_FINISH;
                  end else if (mem_rsp_data[62]) begin
                     real_q  <= leaf_real;
                     leaf_q  <= mem_rsp_data;
                     state_q <= ST_FINISH;
                  end else if (lvl_bad) begin
                     err_q.bad_tree <= 1'b1;
                     state_q        <= ST_FINISH;
                  end else begin
                     shift_q <= shift_q - rsp_idx;
                     idx_q   <= rsp_idx;
                     base_q  <= rsp_base;
                     issue_q <= 1'b1;
                  end
               end
            end
            ST_FINISH: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign done          = (state_q == ST_FINISH);
   assign mem_req_valid = mreq_q;
   assign mem_req_addr  = maddr_q;
   assign real_addr     = real_q;
   assign leaf_entry    = leaf_q;
   assign err_bad_tree  = err_q.bad_tree;
   assign err_invalid   = err_q.invalid;
   assign err_segment   = err_q.segment;

   logic unused_rsp;
   assign unused_rsp = ^{mem_rsp_data[60:56], root_diff[LIM_W-1]};

   // Read-in-flight tracker used only by the checks below.
   logic pend_q;
   always_ff @(posedge clk) begin
      if (!rst_n)             pend_q <= 1'b0;
      else if (mem_req_valid) pend_q <= 1'b1;
      else if (mem_rsp_valid) pend_q <= 1'b0;
   end

   assert_busy_ignores_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   assert_err_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({err_bad_tree, err_invalid, err_segment}) |-> (done || $past(req_ready)));
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_err_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_bad_tree, err_invalid, err_segment}));
   assert_zero_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (err_bad_tree || err_invalid || err_segment)) |-> (real_addr == 64'd0 && leaf_entry == 64'd0));
   assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !pend_q);
endmodule

// File: tb/tb_rpw_walker.sv
module tb_rpw_walker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_ea = '0;
   logic [31:0] req_pid = '0;
   logic [63:0] proc_tbl_base = '0;
   logic        req_ready;
   logic        mem_req_valid;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic [63:0] real_addr, leaf_entry;
   logic        err_bad_tree, err_invalid, err_segment;

   rpw_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
      .req_pid(req_pid), .proc_tbl_base(proc_tbl_base), .req_ready(req_ready),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
      .real_addr(real_addr), .leaf_entry(leaf_entry), .err_bad_tree(err_bad_tree),
      .err_invalid(err_invalid), .err_segment(err_segment)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int tests = 0;
   int fails = 0;

   task automatic check64(input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // Sparse memory model: absent addresses read as zero.
   logic [63:0] mem_tbl [logic [63:0]];
   int          mem_lat = 1;
   int          rd_cnt = 0;
   logic [63:0] rd_first = '0;
   int          ov_err = 0;

   function automatic logic [63:0] rd(input logic [63:0] a);
      if (mem_tbl.exists(a)) return mem_tbl[a];
      return 64'd0;
   endfunction

   initial begin
      int          cnt = 0;
      logic [63:0] pa = '0;
      forever begin
         @(negedge clk);
         if (mem_rsp_valid) mem_rsp_valid = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd(pa);
            end
         end
         if (mem_req_valid) begin
            if (cnt != 0) ov_err++;
            if (rd_cnt == 0) rd_first = mem_req_addr;
            rd_cnt++;
            pa  = mem_req_addr;
            cnt = mem_lat;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic run_walk(input logic [63:0] ea, input logic [31:0] pid,
                           input logic [63:0] ptbr, input int lat,
                           input logic [2:0] exp_err, input logic [63:0] exp_real,
                           input int exp_reads, input logic [63:0] exp_first,
                           input string tag, input bit poke);
      int waited = 0;
      @(negedge clk);
      mem_lat = lat;
      rd_cnt = 0;
      req_ea = ea; req_pid = pid; proc_tbl_base = ptbr; req_valid = 1'b1;
      check64({tag, " R1 ready"}, 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && waited < 2000) begin
         if (poke && waited == 1) begin
            req_valid = 1'b1;
            req_ea = 64'h8000_0000_0000_0000;
            req_pid = 32'd2;
            check64({tag, " R1 busy"}, 64'(req_ready), 64'd0);
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
         waited++;
      end
      req_valid = 1'b0;
      if (!done) begin
         check64({tag, " R10 done seen"}, 64'd0, 64'd1);
      end else begin
         check64({tag, " R10 flags"}, 64'({err_bad_tree, err_invalid, err_segment}), 64'(exp_err));
         check64({tag, " real"}, real_addr, exp_real);
         check64({tag, " R11 reads"}, 64'(rd_cnt), 64'(exp_reads));
         check64({tag, " R2 first read"}, rd_first, exp_first);
      end
      @(negedge clk);
      check64({tag, " R10 done pulse"}, 64'(done), 64'd0);
      check64({tag, " R1 ready back"}, 64'(req_ready), 64'd1);
   endtask

   localparam logic [63:0] PTB   = 64'h0000_0000_0010_0000;
   localparam logic [2:0]  E_OK  = 3'b000;
   localparam logic [2:0]  E_BAD = 3'b100;
   localparam logic [2:0]  E_INV = 3'b010;
   localparam logic [2:0]  E_SEG = 3'b001;

   initial begin
      // Process entries: tree shift 0, root width 10, root base 0x200000.
      mem_tbl[64'h10_0000] = 64'h0000_0000_0020_000A;
      mem_tbl[64'h10_0010] = 64'h0000_0000_0020_000A;
      mem_tbl[64'h10_0020] = 64'h0000_0000_0020_0004;
      mem_tbl[64'h10_0030] = 64'h0000_0000_0020_0011;
      mem_tbl[64'h10_1020] = 64'h0000_0000_0020_000A;
      // Root directory, index ea[30:21].
      mem_tbl[64'h20_0000] = 64'h8000_0000_0040_0009;
      mem_tbl[64'h20_0010] = 64'hC000_0000_4001_F08E;
      mem_tbl[64'h20_0018] = 64'h8000_0000_0050_000C;
      mem_tbl[64'h20_0020] = 64'h8000_0000_0050_0004;
      // Second level, index ea[20:12]: 4 KiB leaves for j = 0..7.
      for (int j = 0; j < 8; j++)
         mem_tbl[64'h40_0000 + 64'(j * 8)] = 64'hC000_0000_0000_0000 | (64'(32'h10000 + j) << 12) | 64'h0A5;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R1 reset ready", 64'(req_ready), 64'd1);
      check64("R10 reset done", 64'(done), 64'd0);
      check64("R11 reset mem_req", 64'(mem_req_valid), 64'd0);
      check64("R10 reset flags", 64'({err_bad_tree, err_invalid, err_segment}), 64'd0);

      // R8/R9: two-level walk to 4 KiB leaves, swept over index and latency.
      for (int lat = 1; lat <= 3; lat++)
         for (int j = 0; j < 8; j++)
            run_walk((64'(j) << 12) | 64'(j * 16), 32'd1, PTB, lat, E_OK,
                     (64'(32'h10000 + j) << 12) | 64'h0A5, 3, 64'h10_0010, "R8_R9 leaf4k", 1'b0);

      // R9: leaf at the root, remaining shift 9 takes ea[20:12].
      for (int k = 0; k < 3; k++) begin
         logic [63:0] kk = (k == 0) ? 64'd0 : (k == 1) ? 64'd5 : 64'h1FF;
         run_walk((64'd2 << 21) | (kk << 12) | 64'h123, 32'd1, PTB, 2, E_OK,
                  64'h4000_0000 | (kk << 12) | 64'h08E, 2, 64'h10_0010, "R9 huge", 1'b0);
      end
      check64("R9 leaf_entry", leaf_entry, 64'hC000_0000_4001_F08E);

      // R3: ea[63]=1 forces PID to zero.
      run_walk(64'hC000_0000_0000_3000, 32'd5, PTB, 1, E_OK,
               (64'h10003 << 12) | 64'h0A5, 3, 64'h10_0000, "R3 quadrant", 1'b0);
      // R2: PID bits 11:8 merged under a 4-bit mask.
      run_walk(64'h5000, 32'h102, PTB | 64'd4, 1, E_OK,
               (64'h10005 << 12) | 64'h0A5, 3, 64'h10_1020, "R2 pid mask", 1'b0);
      // R5: segment faults.
      run_walk(64'h8000_0000_0000_1000, 32'd1, PTB, 1, E_SEG, 64'd0, 1, 64'h10_0000, "R5 top bits", 1'b0);
      run_walk(64'h8000_0000, 32'd1, PTB, 2, E_SEG, 64'd0, 1, 64'h10_0010, "R5 bit31", 1'b0);
      // R4/R6: root width out of range.
      run_walk(64'h1000, 32'd2, PTB, 1, E_BAD, 64'd0, 1, 64'h10_0020, "R4_R6 root small", 1'b0);
      run_walk(64'h1000, 32'd3, PTB, 1, E_BAD, 64'd0, 1, 64'h10_0030, "R6 root large", 1'b0);
      // R6: lower level width above budget, and below minimum.
      run_walk(64'd3 << 21, 32'd1, PTB, 1, E_BAD, 64'd0, 2, 64'h10_0010, "R6 lvl over", 1'b0);
      run_walk(64'd4 << 21, 32'd1, PTB, 3, E_BAD, 64'd0, 2, 64'h10_0010, "R6 lvl small", 1'b0);
      // R7: invalid entries at each level.
      run_walk(64'd1 << 21, 32'd1, PTB, 1, E_INV, 64'd0, 2, 64'h10_0010, "R7 root inv", 1'b0);
      run_walk(64'd8 << 12, 32'd1, PTB, 2, E_INV, 64'd0, 3, 64'h10_0010, "R7 lvl inv", 1'b0);
      // R1: a request raised mid-walk is ignored.
      run_walk(64'd6 << 12, 32'd1, PTB, 3, E_OK,
               (64'h10006 << 12) | 64'h0A5, 3, 64'h10_0010, "R1 poke", 1'b1);
      // R10: flags cleared on the next good walk.
      run_walk(64'd7 << 12, 32'd1, PTB, 1, E_OK,
               (64'h10007 << 12) | 64'h0A5, 3, 64'h10_0010, "R10 clear", 1'b0);

      check64("R11 overlap", 64'(ov_err), 64'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule